// File: doc/BRIEF.md
# Dual-plane block erase sequencer

This block sits on the controller side of a parallel NAND flash bus. It erases two blocks at once, one in each plane. A host hands it two block numbers and a mode bit in a single valid/ready request. The block then drives the whole bus conversation by itself:

- a setup command and three row-address cycles for each block;
- either an intermediate command with a short busy wait (ONFI mode) or a timed gap (traditional mode) between the two address groups;
- the erase confirm command, followed by the wait on the ready/busy line;
- a status read.

If the status reports a failure, the block issues one enhanced status read per plane to find which plane failed. It ends every request with a one-cycle done pulse. The pulse carries the overall fail flag, a per-plane fail vector, a timeout flag and a reject flag.

The block numbers are plane-qualified: bit 0 of a block number is the plane bit. The row address sent on the bus is the block number shifted up by six places, so the six page-within-block bits are always zero. Row byte 0 goes out first. Bus timing comes from parameters: setup cycles before the write strobe falls, strobe-low cycles and hold cycles. The ready/busy input is synchronised inside the block. It is not looked at for a blanking window after each command that starts a busy period. Every busy wait is bounded by a timeout.

Top module: `nand_dual_erase_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A `req_valid` given while a request is in progress is ignored: it changes neither the bus sequence nor the result, and it produces no second done pulse.
- R2: A request whose first block is not in plane 0 (`req_blk0` bit 0 = 1), or whose second block is not in plane 1 (`req_blk1` bit 0 = 0), ends with `done` and `done_reject` = 1, with fail, plane-fail and timeout at 0. The write strobe makes no edge for such a request.
- R3: Each address group is the command 60h (CLE high, ALE low) followed by three address cycles (ALE high, CLE low). The address bytes are row bits 7:0, then 15:8, then 23:16, where row = block number × 64; row bits 5:0 are zero. The first group carries `req_blk0` and the second carries `req_blk1`.
- R4: With `req_onfi` = 1, the command D1h follows the first address group. The second 60h is latched only after R/B# has returned high.
- R5: With `req_onfi` = 0, no command is issued between the groups. The rising strobe of the second 60h comes at least GAP_CYC clock cycles after the rising strobe of the last address byte of the first group.
- R6: The command D0h follows the second group. The status command 70h is latched only after R/B# has returned high. R/B# is ignored for BLANK_CYC cycles after each command that starts a busy period, so a late fall of R/B# is not taken as ready.
- R7: After 70h, one read cycle is made (RE# low, CLE, ALE and the output enable low). Bit 0 of the byte read is reported as `done_fail`.
- R8: When that bit is 1, two enhanced status reads follow. Each one is the command 78h, three address cycles of that plane's block, and one read cycle. Plane 0 is read first. Bit 0 of each byte read goes to `done_plane_fail[0]` and `done_plane_fail[1]` respectively. When the bit is 0, 78h is never issued and `done_plane_fail` = 00.
- R9: If R/B# stays low for TMO_CYC cycles in any wait, the request ends with `done_timeout` = 1 and `done_fail` = 0, and no further bus cycle is made.
- R10: Every command or address cycle has exactly one of CLE and ALE high. WE# stays low for exactly T_WP cycles, and IO is held stable from the fall of WE# through its rise.
- R11: `done` is a pulse one cycle long, and `req_ready` is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_onfi | input | 1 | 1: intermediate-command flow, 0: timed-gap flow |
| req_blk0 | input | BLK_W | Block number for plane 0 (bit 0 must be 0) |
| req_blk1 | input | BLK_W | Block number for plane 1 (bit 0 must be 1) |
| done | output | 1 | One-cycle completion pulse |
| done_fail | output | 1 | Status bit 0 of the final status read |
| done_plane_fail | output | 2 | Per-plane failure from the enhanced reads |
| done_timeout | output | 1 | Busy wait exceeded TMO_CYC |
| done_reject | output | 1 | Request refused for wrong plane bits |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | IO bus value driven |
| nand_io_oe | output | 1 | IO bus output enable |
| nand_io_in | input | 8 | IO bus value read |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The hardest case to reach from the ports is R/B# falling late. The flash must pull the line low only after the sequencer has finished the confirm command. A design without blanking, or with too short a window, would then see a ready level that is stale and issue the status read too early.

The bench's flash model delays the fall of R/B# by a few cycles after each D1h or D0h it latches. It then checks that the next command is latched only after the cycle in which the model released the line.

The enhanced per-plane reads appear only when the first status byte reports failure. Per-request random fail bits drive both branches, with both plane orders. The timeout path is reached with a model that never releases R/B# after D0h.

// File: rtl/nde_pkg.sv
package nde_pkg;

  localparam logic [7:0] OPC_SETUP = 8'h60;
  localparam logic [7:0] OPC_MID   = 8'hD1;
  localparam logic [7:0] OPC_GO    = 8'hD0;
  localparam logic [7:0] OPC_STAT  = 8'h70;
  localparam logic [7:0] OPC_PSTAT = 8'h78;

  typedef enum logic [2:0] {
    K_CMD, K_ADDR, K_READ, K_WAITRB, K_GAP, K_SKIP, K_BRANCH, K_END
  } kind_e;

  typedef enum logic [1:0] {TG_NONE, TG_SR, TG_P0, TG_P1} tgt_e;

  typedef struct packed {
    kind_e      kind;
    tgt_e       tgt;
    logic [7:0] data;
  } uop_t;

  localparam logic [4:0] STEP_END = 5'd25;

  // row address of a block: page bits 5:0 forced to zero
  function automatic logic [23:0] blk_row(logic [23:0] blk);
    return {blk[17:0], 6'b000000};
  endfunction

  function automatic logic [7:0] row_byte(logic [23:0] row, logic [1:0] idx);
    logic [23:0] sh;
    sh = row >> (5'd8 * {3'b000, idx});
    return sh[7:0];
  endfunction

  function automatic logic planes_ok(logic b0_lsb, logic b1_lsb);
    return !b0_lsb && b1_lsb;
  endfunction

  // micro-program of one dual erase request
  function automatic uop_t step_uop(logic [4:0] s, logic onfi,
                                    logic [23:0] r0, logic [23:0] r1);
    uop_t u;
    u.kind = K_END;
    u.tgt  = TG_NONE;
    u.data = 8'h00;
    case (s)
      5'd0, 5'd6:  begin u.kind = K_CMD; u.data = OPC_SETUP; end
      5'd1, 5'd2, 5'd3: begin
        u.kind = K_ADDR; u.data = row_byte(r0, 2'(s - 5'd1));
      end
      5'd4: begin
        u.kind = onfi ? K_CMD : K_GAP;
        u.data = onfi ? OPC_MID : 8'h00;
      end
      5'd5:  u.kind = onfi ? K_WAITRB : K_SKIP;
      5'd7, 5'd8, 5'd9: begin
        u.kind = K_ADDR; u.data = row_byte(r1, 2'(s - 5'd7));
      end
      5'd10: begin u.kind = K_CMD; u.data = OPC_GO; end
      5'd11: u.kind = K_WAITRB;
      5'd12: begin u.kind = K_CMD; u.data = OPC_STAT; end
      5'd13: begin u.kind = K_READ; u.tgt = TG_SR; end
      5'd14: u.kind = K_BRANCH;
      5'd15, 5'd20: begin u.kind = K_CMD; u.data = OPC_PSTAT; end
      5'd16, 5'd17, 5'd18: begin
        u.kind = K_ADDR; u.data = row_byte(r0, 2'(s - 5'd16));
      end
      5'd19: begin u.kind = K_READ; u.tgt = TG_P0; end
      5'd21, 5'd22, 5'd23: begin
        u.kind = K_ADDR; u.data = row_byte(r1, 2'(s - 5'd21));
      end
      5'd24: begin u.kind = K_READ; u.tgt = TG_P1; end
      default: u.kind = K_END;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/nde_bus_cycle.sv
module nde_bus_cycle #(
  parameter int T_SU = 1,
  parameter int T_WP = 2,
  parameter int T_WH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_read,
  input  logic       is_addr,
  input  logic [7:0] wdata,
  input  logic [7:0] io_in,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic [7:0] rdata,
  output logic       done
);
  localparam int T_MAX = (T_SU > T_WP) ? ((T_SU > T_WH) ? T_SU : T_WH)
                                       : ((T_WP > T_WH) ? T_WP : T_WH);
  localparam int CW = $clog2(T_MAX + 1);

  typedef enum logic [1:0] {B_IDLE, B_SU, B_LO, B_HI} bph_e;
  bph_e          ph;
  logic [CW-1:0] cnt;
  logic          rd_l;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= B_IDLE; cnt <= '0; rd_l <= 1'b0;
      cle <= 1'b0; ale <= 1'b0; we_n <= 1'b1; re_n <= 1'b1;
      io_out <= 8'h00; io_oe <= 1'b0; rdata <= 8'h00; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        B_IDLE: if (start) begin
          ph     <= B_SU;
          cnt    <= CW'(T_SU - 1);
          rd_l   <= is_read;
          cle    <= !is_read && !is_addr;
          ale    <= !is_read && is_addr;
          io_out <= wdata;
          io_oe  <= !is_read;
        end
        B_SU: if (cnt_zero) begin
          ph  <= B_LO;
          cnt <= CW'(T_WP - 1);
          if (rd_l) re_n <= 1'b0;
          else      we_n <= 1'b0;
        end else cnt <= cnt - 1'b1;
        B_LO: if (cnt_zero) begin
          ph   <= B_HI;
          cnt  <= CW'(T_WH - 1);
          we_n <= 1'b1;
          re_n <= 1'b1;
          if (rd_l) rdata <= io_in;
        end else cnt <= cnt - 1'b1;
        default: if (cnt_zero) begin
          ph    <= B_IDLE;
          done  <= 1'b1;
          cle   <= 1'b0;
          ale   <= 1'b0;
          io_oe <= 1'b0;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R10: command and address latches never both high
  a_r10_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R10: data held while the strobe is low and at its rise
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || $rose(we_n)) |-> ($stable(io_out) && io_oe && (cle || ale)));
  // R7: read strobe only with latches and driver off
  a_r7_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> (!cle && !ale && !io_oe && we_n));
endmodule

// File: rtl/nde_busy_wait.sv
module nde_busy_wait #(
  parameter int BLANK_CYC = 8,
  parameter int GAP_CYC   = 16,
  parameter int TMO_CYC   = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic use_rb,
  input  logic rb_n,
  output logic done,
  output logic timeout
);
  localparam int CMAX = (BLANK_CYC > GAP_CYC) ? BLANK_CYC : GAP_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int TW   = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {W_IDLE, W_BLANK, W_RB, W_GAP} wph_e;
  wph_e          ph;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmo;
  logic          rb_m, rb_s;
  logic          rb_seen_ev;
  logic [CW-1:0] since;
  logic          rb_mode;

  assign rb_seen_ev = (ph == W_RB) && rb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_m <= 1'b1; rb_s <= 1'b1;
    end else begin
      rb_m <= rb_n; rb_s <= rb_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= W_IDLE; cnt <= '0; tmo <= '0; done <= 1'b0; timeout <= 1'b0;
      since <= '0; rb_mode <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      if (start) since <= '0;
      else if (since != CW'(CMAX)) since <= since + 1'b1;
      case (ph)
        W_IDLE: if (start) begin
          rb_mode <= use_rb;
          ph  <= use_rb ? W_BLANK : W_GAP;
          cnt <= use_rb ? CW'(BLANK_CYC - 1) : CW'(GAP_CYC - 1);
        end
        W_BLANK: if (cnt == '0) begin
          ph <= W_RB; tmo <= '0;
        end else cnt <= cnt - 1'b1;
        W_RB: if (rb_s) begin
          ph <= W_IDLE; done <= 1'b1;
        end else if (tmo == TW'(TMO_CYC - 1)) begin
          ph <= W_IDLE; done <= 1'b1; timeout <= 1'b1;
        end else tmo <= tmo + 1'b1;
        default: if (cnt == '0) begin
          ph <= W_IDLE; done <= 1'b1;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R6: a ready seen by this unit never falls inside the blanking window
  a_r6_blank_window: assert property (@(posedge clk) disable iff (!rst_n)
    rb_seen_ev |-> (since >= CW'(BLANK_CYC)));
  // R9: timeout only while the synchronised line still reads busy
  a_r9_tmo_busy: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (done && !$past(rb_s) && rb_mode));
  // R5: a gap wait ends no earlier than GAP_CYC cycles after its start
  a_r5_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rb_mode) |-> (since >= CW'(GAP_CYC - 1)));
endmodule

// File: rtl/nand_dual_erase_seq.sv
module nand_dual_erase_seq
  import nde_pkg::*;
#(
  parameter int BLK_W     = 18,
  parameter int T_SU      = 1,
  parameter int T_WP      = 2,
  parameter int T_WH      = 2,
  parameter int BLANK_CYC = 8,
  parameter int GAP_CYC   = 16,
  parameter int TMO_CYC   = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_onfi,
  input  logic [BLK_W-1:0] req_blk0,
  input  logic [BLK_W-1:0] req_blk1,
  output logic             done,
  output logic             done_fail,
  output logic [1:0]       done_plane_fail,
  output logic             done_timeout,
  output logic             done_reject,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb_n
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
  st_e         st;
  logic [4:0]  step;
  logic        onfi_l;
  logic [23:0] row0, row1;
  logic        sr0;
  logic [1:0]  pf;
  uop_t        cur;

  logic        bus_start, bus_done;
  logic [7:0]  bus_rdata;
  logic        wait_start, wait_done, wait_tmo;
  logic        accept_ev, reject_ev, finish_ev;

  assign cur        = step_uop(step, onfi_l, row0, row1);
  assign req_ready  = (st == S_IDLE);
  assign accept_ev  = req_ready && req_valid;
  assign reject_ev  = accept_ev && !planes_ok(req_blk0[0], req_blk1[0]);
  assign finish_ev  = (st == S_ISSUE) && (cur.kind == K_END);
  assign bus_start  = (st == S_ISSUE) &&
                      (cur.kind == K_CMD || cur.kind == K_ADDR || cur.kind == K_READ);
  assign wait_start = (st == S_ISSUE) && (cur.kind == K_WAITRB || cur.kind == K_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= 5'd0; onfi_l <= 1'b0; row0 <= '0; row1 <= '0;
      sr0 <= 1'b0; pf <= 2'b00;
      done <= 1'b0; done_fail <= 1'b0; done_plane_fail <= 2'b00;
      done_timeout <= 1'b0; done_reject <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept_ev) begin
          if (reject_ev) begin
            done <= 1'b1; done_reject <= 1'b1; done_fail <= 1'b0;
            done_plane_fail <= 2'b00; done_timeout <= 1'b0;
          end else begin
            st     <= S_ISSUE;
            step   <= 5'd0;
            onfi_l <= req_onfi;
            row0   <= blk_row(24'(req_blk0));
            row1   <= blk_row(24'(req_blk1));
            sr0    <= 1'b0;
            pf     <= 2'b00;
          end
        end
        S_ISSUE: case (cur.kind)
          K_SKIP:   step <= step + 5'd1;
          K_BRANCH: step <= sr0 ? step + 5'd1 : STEP_END;
          K_END: begin
            st <= S_IDLE; done <= 1'b1; done_fail <= sr0;
            done_plane_fail <= pf; done_timeout <= 1'b0; done_reject <= 1'b0;
          end
          default:  st <= S_WAIT;
        endcase
        default: begin
          if (bus_done) begin
            if (cur.kind == K_READ) begin
              case (cur.tgt)
                TG_SR:   sr0   <= bus_rdata[0];
                TG_P0:   pf[0] <= bus_rdata[0];
                TG_P1:   pf[1] <= bus_rdata[0];
                default: ;
              endcase
            end
            step <= step + 5'd1;
            st   <= S_ISSUE;
          end else if (wait_done) begin
            if (wait_tmo) begin
              st <= S_IDLE; done <= 1'b1; done_timeout <= 1'b1;
              done_fail <= 1'b0; done_plane_fail <= 2'b00; done_reject <= 1'b0;
            end else begin
              step <= step + 5'd1;
              st   <= S_ISSUE;
            end
          end
        end
      endcase
    end
  end

  nde_bus_cycle #(.T_SU(T_SU), .T_WP(T_WP), .T_WH(T_WH)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start),
    .is_read(cur.kind == K_READ), .is_addr(cur.kind == K_ADDR),
    .wdata(cur.data), .io_in(nand_io_in),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .io_out(nand_io_out), .io_oe(nand_io_oe), .rdata(bus_rdata), .done(bus_done)
  );

  nde_busy_wait #(.BLANK_CYC(BLANK_CYC), .GAP_CYC(GAP_CYC), .TMO_CYC(TMO_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .start(wait_start), .use_rb(cur.kind == K_WAITRB),
    .rb_n(nand_rb_n), .done(wait_done), .timeout(wait_tmo)
  );

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: while accepting, the bus is quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));
  // R2: a reject carries no other result
  a_r2_reject_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_reject) |-> (!done_fail && !done_timeout && done_plane_fail == 2'b00));
  // R8: plane vector empty when the overall status passed
  a_r8_planes_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_fail) |-> (done_plane_fail == 2'b00));
  // R9: timeout and erase failure are exclusive
  a_r9_tmo_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_timeout) |-> (!done_fail && !done_reject));
  // R1: the bus cycle engine is only started by an accepted request
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || wait_start) |-> !req_ready);
endmodule

// File: tb/nand_dual_erase_seq_test.sv
module nand_dual_erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 18;
  localparam int T_WP = 2;
  localparam int BLANK_CYC = 8;
  localparam int GAP_CYC = 16;
  localparam int TMO_CYC = 2000;
  localparam int ONFI_BUSY = 10;
  localparam int ERASE_BUSY = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_onfi = 1'b0;
  logic [BLK_W-1:0] req_blk0 = '0, req_blk1 = '0;
  logic req_ready, done, done_fail, done_timeout, done_reject;
  logic [1:0] done_plane_fail;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_out, nand_io_in;
  logic nand_rb_n = 1'b1;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_dual_erase_seq #(.BLK_W(BLK_W), .T_WP(T_WP), .BLANK_CYC(BLANK_CYC),
    .GAP_CYC(GAP_CYC), .TMO_CYC(TMO_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_onfi(req_onfi), .req_blk0(req_blk0), .req_blk1(req_blk1),
    .done(done), .done_fail(done_fail), .done_plane_fail(done_plane_fail),
    .done_timeout(done_timeout), .done_reject(done_reject),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n));

  // flash model state
  int cyc = 0;
  int log_n = 0;
  int log_k[64];
  int log_d[64];
  int log_t[64];
  int exp_n = 0;
  int exp_k[64];
  int exp_d[64];
  int rb_lo_at = 0, rb_hi_at = 0, d1_hi = 0, d0_hi = 0;
  int we_low = 0, bus_bad = 0;
  bit hang_m = 0, pf0_m = 0, pf1_m = 0, last_plane = 0;
  bit prev_we = 1, prev_re = 1;
  int last_cmd = 0, addr_idx = 0;

  assign nand_io_in = (last_cmd == 8'h70) ? {7'b1110000, pf0_m | pf1_m}
                                          : {7'b1010000, last_plane ? pf1_m : pf0_m};

  function automatic void check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (nand_cle && nand_ale) bus_bad = bus_bad + 1;
    if (!nand_we_n) we_low = we_low + 1;
    if (!prev_we && nand_we_n) begin
      if (we_low != T_WP) bus_bad = bus_bad + 1;
      we_low = 0;
      if (log_n < 64) begin
        log_k[log_n] = nand_cle ? 1 : (nand_ale ? 2 : 0);
        log_d[log_n] = int'(nand_io_out);
        log_t[log_n] = cyc;
        log_n = log_n + 1;
      end
      if (nand_cle) begin
        last_cmd = int'(nand_io_out);
        addr_idx = 0;
        if (nand_io_out == 8'hD1) begin
          rb_lo_at = cyc + 2; rb_hi_at = cyc + 2 + ONFI_BUSY; d1_hi = rb_hi_at;
        end
        if (nand_io_out == 8'hD0) begin
          rb_lo_at = cyc + 3;
          rb_hi_at = hang_m ? 32'h7fffffff : cyc + 3 + ERASE_BUSY;
          d0_hi = rb_hi_at;
        end
      end else if (nand_ale) begin
        if (addr_idx == 0) last_plane = nand_io_out[6];
        addr_idx = addr_idx + 1;
      end
    end
    if (!prev_re && nand_re_n && log_n < 64) begin
      log_k[log_n] = 3; log_d[log_n] = int'(nand_io_in);
      log_t[log_n] = cyc; log_n = log_n + 1;
    end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
    nand_rb_n = !(cyc >= rb_lo_at && cyc < rb_hi_at);
  end

  function automatic void push(int k, int d);
    exp_k[exp_n] = k; exp_d[exp_n] = d; exp_n = exp_n + 1;
  endfunction

  // row = block * 64, three bytes low first
  function automatic void push_row(int b);
    push(2, (b % 4) * 64);
    push(2, (b / 4) % 256);
    push(2, (b / 1024) % 256);
  endfunction

  task automatic build_exp(bit onfi, int b0, int b1, bit f0, bit f1, bit hang);
    exp_n = 0;
    push(1, 8'h60); push_row(b0);
    if (onfi) push(1, 8'hD1);
    push(1, 8'h60); push_row(b1);
    push(1, 8'hD0);
    if (!hang) begin
      push(1, 8'h70); push(3, 8'hE0 | int'(f0 | f1));
      if (f0 | f1) begin
        push(1, 8'h78); push_row(b0); push(3, 8'hA0 | int'(f0));
        push(1, 8'h78); push_row(b1); push(3, 8'hA0 | int'(f1));
      end
    end
  endtask

  task automatic run_req(bit onfi, int b0, int b1, bit f0, bit f1, bit hang, bit poke);
    bit rej, got;
    int n, first_bad;
    rej = !((b0 % 2) == 0 && (b1 % 2) == 1);
    pf0_m = f0; pf1_m = f1; hang_m = hang;
    rb_lo_at = 0; rb_hi_at = 0; d1_hi = 0; d0_hi = 0;
    @(negedge clk);
    log_n = 0; bus_bad = 0;
    build_exp(onfi, b0, b1, f0, f1, hang);
    check(req_ready == 1'b1, "R1 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_onfi = onfi;
    req_blk0 = BLK_W'(b0); req_blk1 = BLK_W'(b1);
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; n = 0;
    if (rej) begin
      got = done;
    end else begin
      while (!got && n < 20000) begin
        if (poke && n == 20) begin
          check(req_ready == 1'b0, "R1 ready low while busy", int'(req_ready), 0);
          req_valid = 1'b1; req_blk0 = BLK_W'(b0 ^ 6); req_blk1 = BLK_W'(b1 ^ 6);
          req_onfi = !onfi;
        end
        if (poke && n == 21) req_valid = 1'b0;
        @(negedge clk);
        n++;
        got = done;
      end
    end
    check(got, "R11 done seen", int'(got), 1);
    check(done_reject == rej, "R2 reject flag", int'(done_reject), int'(rej));
    check(done_timeout == (hang && !rej), "R9 timeout flag", int'(done_timeout),
          int'(hang && !rej));
    check(done_fail == (!rej && !hang && (f0 | f1)), "R7 fail flag", int'(done_fail),
          int'(!rej && !hang && (f0 | f1)));
    check(done_plane_fail == ((!rej && !hang && (f0 | f1)) ? {f1, f0} : 2'b00),
          "R8 plane fail vector", int'(done_plane_fail),
          (!rej && !hang && (f0 | f1)) ? int'({f1, f0}) : 0);
    @(negedge clk);
    check(done == 1'b0 && req_ready == 1'b1, "R11 pulse ends, ready back",
          int'({done, req_ready}), 1);
    if (rej) begin
      repeat (4) @(negedge clk);
      check(log_n == 0, "R2 no strobe on reject", log_n, 0);
    end else begin
      repeat (4) @(negedge clk);
      check(log_n == exp_n, "R3 bus cycle count", log_n, exp_n);
      first_bad = -1;
      for (int i = 0; i < exp_n && i < log_n; i++)
        if (first_bad < 0 && (log_k[i] != exp_k[i] || log_d[i] != exp_d[i])) first_bad = i;
      if (first_bad >= 0)
        check(0, "R3 R8 bus sequence", log_k[first_bad] * 256 + log_d[first_bad],
              exp_k[first_bad] * 256 + exp_d[first_bad]);
      else check(1, "R3 bus sequence", 0, 0);
      check(bus_bad == 0, "R10 strobe width and latch exclusivity", bus_bad, 0);
      if (log_n == exp_n) begin
        if (onfi) check(log_t[5] > d1_hi, "R4 second setup after ready", log_t[5], d1_hi);
        else check(log_t[4] - log_t[3] >= GAP_CYC, "R5 gap between groups",
                   log_t[4] - log_t[3], GAP_CYC);
        if (!hang) begin
          n = onfi ? 10 : 9;
          check(log_t[n] > d0_hi, "R6 status after erase ready", log_t[n], d0_hi);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(req_ready == 1 && done == 0 && nand_we_n == 1 && nand_re_n == 1 &&
          nand_cle == 0 && nand_ale == 0, "R1 reset state",
          int'({req_ready, done, nand_we_n, nand_re_n, nand_cle, nand_ale}), 6'b101100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_req(0, 10, 11, 0, 0, 0, 0);
    run_req(1, 10, 11, 0, 0, 0, 0);
    run_req(1, 4, 7, 1, 0, 0, 0);
    run_req(0, 100, 333, 0, 1, 0, 0);
    run_req(1, 2, 3, 1, 1, 0, 0);
    run_req(0, 3, 5, 0, 0, 0, 0);
    run_req(1, 8, 8, 0, 0, 0, 0);
    run_req(0, 262142, 262143, 1, 1, 0, 0);
    run_req(1, 0, 1, 0, 0, 1, 0);
    run_req(0, 20, 41, 1, 0, 0, 1);
    for (int k = 0; k < 16; k++) begin
      int b0, b1, sel;
      b0 = int'($urandom & 32'h3FFFE);
      b1 = int'(($urandom & 32'h3FFFF) | 1);
      sel = int'($urandom % 8);
      if (sel == 0) b0 = b0 | 1;
      run_req(bit'($urandom % 2), b0, b1, bit'($urandom % 2), bit'($urandom % 2),
              sel == 1, sel == 2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule